// File: doc/BRIEF.md
# Segmented-Address Bus Cycle Sequencer

This block runs one bus cycle at a time on a multiplexed address/data bus for a 16-bit processor core. The core presents a request with a segment value, an offset, a code that names the segment, a memory-or-I/O select, a direction, write data and the current interrupt-enable flag. The sequencer forms a 20-bit physical address from the segment and offset. It then steps through four bus states, T1 to T4, and drives the shared lines and the bus strobes in each state.

In T1 the block puts the full address on the bus and pulses the address latch strobe. In T2 to T4 the four upper lines change to a status code. On a write the lower lines carry the write data in those states. On a read the lower lines are released, and the value on them is sampled at the end of T3 and returned to the core. A done pulse in T4 marks the end of the cycle. The block accepts a new request only while it is idle.

Top module: `busCycleSeq`

## Requirements
- R1: In reset and in idle: reqReady=1, ale=0, rdN=1, wrN=1, denN=1, adOe=0, doneValid=0, busHi=0. An asserted rstN=0 in the middle of a cycle returns the outputs to this state at the next clock edge.
- R2: A request with reqValid=1 is taken at a clock edge only while reqReady=1. The cycle then spans four clocks, T1 to T4. doneValid is 1 in T4 only, and reqReady is 1 again in the clock after T4. Request inputs that change during T1 to T4 have no effect on that cycle.
- R3: The physical address equals (reqSeg shifted left by 4) + reqOff, taken modulo 2^20. In T1, adOut carries address bits 15..0 with adOe=1, and busHi carries address bits 19..16.
- R4: ale is 1 during T1 and 0 in every other state.
- R5: memIo equals reqIsMem (1 for memory, 0 for I/O) from T1 to T4, and is 1 when idle.
- R6: dtR equals reqIsWrite (1 for a write, 0 for a read) from T1 to T4, and is 0 when idle.
- R7: From T2 to T4, rdN=0 on a read and wrN=0 on a write, and the other strobe stays 1. Both strobes are 1 in T1 and when idle.
- R8: denN is 0 from T2 to T4 and 1 in T1 and when idle.
- R9: From T2 to T4, busHi = {1'b0, intEn, segId}. busHi[3] is always 0, busHi[2] is the interrupt flag, and segId uses the codes 0=ES, 1=SS, 2=CS or none, 3=DS.
- R10: On a write, adOut equals the write data and adOe=1 from T2 to T4. On a read, adOe=0 from T2 to T4.
- R11: On a read, adIn is sampled at the end of T3. The value appears on rdData in T4 and stays there until the next read sample. Changes to adIn in T4 or later have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqSeg | input | 16 | Segment value |
| reqOff | input | 16 | Offset within the segment |
| reqSegId | input | 2 | Segment code: 0 ES, 1 SS, 2 CS or none, 3 DS |
| reqIsMem | input | 1 | 1 for memory, 0 for I/O |
| reqIsWrite | input | 1 | 1 for write, 0 for read |
| reqWData | input | 16 | Write data |
| reqIntEn | input | 1 | Interrupt-enable flag state |
| reqReady | output | 1 | Idle, so a request can be accepted |
| doneValid | output | 1 | Pulse in T4 |
| rdData | output | 16 | Read data that was sampled |
| adIn | input | 16 | Lower bus lines, input side |
| adOut | output | 16 | Lower bus lines, output side |
| adOe | output | 1 | Output enable for the lower lines |
| busHi | output | 4 | Upper lines: address bits 19..16 in T1, status in T2 to T4 |
| ale | output | 1 | Address latch strobe |
| rdN | output | 1 | Read strobe, active low |
| wrN | output | 1 | Write strobe, active low |
| memIo | output | 1 | Memory (1) or I/O (0) |
| dtR | output | 1 | Transceiver direction: 1 transmit, 0 receive |
| denN | output | 1 | Data enable, active low |

## Verification
Most internal faults in this block show up at the pins within the same bus state in which they occur. A wrong state register shifts ale, denN or a data strobe by a whole clock, or stretches doneValid, so a check in each of T1 to T4 catches it in that cycle. If the request registers are loaded while the block is busy, or a captured field is wrong, the result is a wrong address in T1 or a wrong status code in T2. A wrong sampling point shows up as a mismatch on rdData in T4, or in the idle cycle after it when adIn is disturbed in T4.

// File: rtl/busSeqPkg.sv
package busSeqPkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_T3   = 3'd3,
    ST_T4   = 3'd4
  } busState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;      // take request fields
    logic busy;      // inside T1..T4
    logic addrPhase; // T1
    logic dataPhase; // T2..T4
    logic capture;   // end of T3
    logic finish;    // T4
  } seqCtrl_t;
endpackage

// File: rtl/busSeqCtrl.sv
module busSeqCtrl
  import busSeqPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  output logic     reqReady,
  output seqCtrl_t ctrl
);
  busState_t stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE: if (reqValid) stateD = ST_T1;
      ST_T1:   stateD = ST_T2;
      ST_T2:   stateD = ST_T3;
      ST_T3:   stateD = ST_T4;
      ST_T4:   stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    reqReady       = (stateQ == ST_IDLE);
    ctrl.load      = reqReady && reqValid;
    ctrl.busy      = !reqReady;
    ctrl.addrPhase = (stateQ == ST_T1);
    ctrl.dataPhase = (stateQ == ST_T2) || (stateQ == ST_T3) || (stateQ == ST_T4);
    ctrl.capture   = (stateQ == ST_T3);
    ctrl.finish    = (stateQ == ST_T4);
  end
endmodule

// File: rtl/busSeqDatapath.sv
module busSeqDatapath
  import busSeqPkg::*;
#(
  parameter int SEG_W     = 16,
  parameter int SEG_SHIFT = 4,
  parameter int DATA_W    = 16,
  parameter int SID_W     = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqCtrl_t            ctrl,
  input  logic [SEG_W-1:0]    reqSeg,
  input  logic [DATA_W-1:0]   reqOff,
  input  logic [SID_W-1:0]    reqSegId,
  input  logic                reqIsMem,
  input  logic                reqIsWrite,
  input  logic [DATA_W-1:0]   reqWData,
  input  logic                reqIntEn,
  input  logic [DATA_W-1:0]   adIn,
  output logic [DATA_W-1:0]   adOut,
  output logic                adOe,
  output logic [SEG_W+SEG_SHIFT-DATA_W-1:0] busHi,
  output logic [DATA_W-1:0]   rdData,
  output logic                ale,
  output logic                rdN,
  output logic                wrN,
  output logic                memIo,
  output logic                dtR,
  output logic                denN
);
  localparam int PA_W = SEG_W + SEG_SHIFT;
  localparam int HI_W = PA_W - DATA_W;
  localparam int PAD_W = PA_W - DATA_W;

  logic [PA_W-1:0]   paQ;
  logic [PA_W-1:0]   paSum;
  logic [SID_W-1:0]  segIdQ;
  logic              isMemQ, isWrQ, intEnQ;
  logic [DATA_W-1:0] wDataQ, rDataQ;
  logic [HI_W-1:0]   statusCode;

  // address adder, wraps at PA_W bits
  assign paSum = {reqSeg, {SEG_SHIFT{1'b0}}} + {{PAD_W{1'b0}}, reqOff};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      paQ    <= '0;
      segIdQ <= '0;
      isMemQ <= 1'b1;
      isWrQ  <= 1'b0;
      intEnQ <= 1'b0;
      wDataQ <= '0;
    end else if (ctrl.load) begin
      paQ    <= paSum;
      segIdQ <= reqSegId;
      isMemQ <= reqIsMem;
      isWrQ  <= reqIsWrite;
      intEnQ <= reqIntEn;
      wDataQ <= reqWData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                       rDataQ <= '0;
    else if (ctrl.capture && !isWrQ) rDataQ <= adIn;
  end

  // top status line is always low
  assign statusCode = HI_W'({1'b0, intEnQ, segIdQ});

  always_comb begin
    ale   = ctrl.addrPhase;
    denN  = !ctrl.dataPhase;
    rdN   = !(ctrl.dataPhase && !isWrQ);
    wrN   = !(ctrl.dataPhase && isWrQ);
    memIo = ctrl.busy ? isMemQ : 1'b1;
    dtR   = ctrl.busy ? isWrQ : 1'b0;
    adOe  = ctrl.addrPhase || (ctrl.dataPhase && isWrQ);
    if (ctrl.addrPhase)                adOut = paQ[DATA_W-1:0];
    else if (ctrl.dataPhase && isWrQ)  adOut = wDataQ;
    else                               adOut = '0;
    if (ctrl.addrPhase)      busHi = paQ[PA_W-1:DATA_W];
    else if (ctrl.dataPhase) busHi = statusCode;
    else                     busHi = '0;
  end

  assign rdData = rDataQ;
endmodule

// File: rtl/busCycleSeq.sv
module busCycleSeq
  import busSeqPkg::*;
#(
  parameter int SEG_W     = 16,
  parameter int SEG_SHIFT = 4,
  parameter int DATA_W    = 16,
  parameter int SID_W     = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [SEG_W-1:0]  reqSeg,
  input  logic [DATA_W-1:0] reqOff,
  input  logic [SID_W-1:0]  reqSegId,
  input  logic              reqIsMem,
  input  logic              reqIsWrite,
  input  logic [DATA_W-1:0] reqWData,
  input  logic              reqIntEn,
  output logic              reqReady,
  output logic              doneValid,
  output logic [DATA_W-1:0] rdData,
  input  logic [DATA_W-1:0] adIn,
  output logic [DATA_W-1:0] adOut,
  output logic              adOe,
  output logic [SEG_W+SEG_SHIFT-DATA_W-1:0] busHi,
  output logic              ale,
  output logic              rdN,
  output logic              wrN,
  output logic              memIo,
  output logic              dtR,
  output logic              denN
);
  seqCtrl_t ctrl;

  busSeqCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqReady (reqReady),
    .ctrl     (ctrl)
  );

  busSeqDatapath #(
    .SEG_W(SEG_W), .SEG_SHIFT(SEG_SHIFT), .DATA_W(DATA_W), .SID_W(SID_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .reqSeg     (reqSeg),
    .reqOff     (reqOff),
    .reqSegId   (reqSegId),
    .reqIsMem   (reqIsMem),
    .reqIsWrite (reqIsWrite),
    .reqWData   (reqWData),
    .reqIntEn   (reqIntEn),
    .adIn       (adIn),
    .adOut      (adOut),
    .adOe       (adOe),
    .busHi      (busHi),
    .rdData     (rdData),
    .ale        (ale),
    .rdN        (rdN),
    .wrN        (wrN),
    .memIo      (memIo),
    .dtR        (dtR),
    .denN       (denN)
  );

  assign doneValid = ctrl.finish;
endmodule

// File: rtl/busCycleSeqChk.sv
module busCycleSeqChk (
  input logic       clk,
  input logic       rstN,
  input logic       reqReady,
  input logic       doneValid,
  input logic       adOe,
  input logic [3:0] busHi,
  input logic       ale,
  input logic       rdN,
  input logic       wrN,
  input logic       denN
);
  AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    ale |=> !ale); // R4
  AST_ALE_NO_DATA: assert property (@(posedge clk) disable iff (!rstN)
    ale |-> (rdN && wrN && denN)); // R8
  AST_DEN_AFTER_ALE: assert property (@(posedge clk) disable iff (!rstN)
    ale |=> !denN); // R8
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(!rdN && !wrN)); // R7
  AST_READ_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    !rdN |-> !adOe); // R10
  AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> (reqReady && !doneValid)); // R2
  AST_S6_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !denN |-> !busHi[3]); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (!ale && rdN && wrN && denN)); // R1
endmodule

bind busCycleSeq busCycleSeqChk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .reqReady  (reqReady),
  .doneValid (doneValid),
  .adOe      (adOe),
  .busHi     (busHi),
  .ale       (ale),
  .rdN       (rdN),
  .wrN       (wrN),
  .denN      (denN)
);

// File: tb/test_busCycleSeq.sv
module test_busCycleSeq;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [15:0] reqSeg = '0, reqOff = '0, reqWData = '0, adIn = '0;
  logic [1:0] reqSegId = '0;
  logic reqIsMem = 1'b0, reqIsWrite = 1'b0, reqIntEn = 1'b0;
  logic reqReady, doneValid, adOe, ale, rdN, wrN, memIo, dtR, denN;
  logic [15:0] rdData, adOut;
  logic [3:0] busHi;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  busCycleSeq i_busCycleSeq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqSeg(reqSeg), .reqOff(reqOff),
    .reqSegId(reqSegId), .reqIsMem(reqIsMem), .reqIsWrite(reqIsWrite),
    .reqWData(reqWData), .reqIntEn(reqIntEn), .reqReady(reqReady),
    .doneValid(doneValid), .rdData(rdData), .adIn(adIn), .adOut(adOut),
    .adOe(adOe), .busHi(busHi), .ale(ale), .rdN(rdN), .wrN(wrN),
    .memIo(memIo), .dtR(dtR), .denN(denN)
  );

  typedef struct packed {
    logic [15:0] seg;
    logic [15:0] off;
    logic [1:0]  sid;
    logic        mem;
    logic        wr;
    logic [15:0] wd;
    logic        ie;
    logic [15:0] rd;
    logic [19:0] pa;
  } vec_t;

  // segId: 0 ES, 1 SS, 2 CS, 3 DS
  localparam vec_t VECS [6] = '{
    '{16'h348A, 16'h4214, 2'd2, 1'b1, 1'b0, 16'h0000, 1'b1, 16'h5A5A, 20'h38AB4},
    '{16'h7000, 16'h0020, 2'd3, 1'b1, 1'b1, 16'hBEEF, 1'b0, 16'h0000, 20'h70020},
    '{16'h1550, 16'h0050, 2'd0, 1'b1, 1'b0, 16'h0000, 1'b0, 16'h1234, 20'h15550},
    '{16'h2022, 16'h40C3, 2'd1, 1'b1, 1'b1, 16'h00FA, 1'b1, 16'h0000, 20'h242E3},
    '{16'h0000, 16'h0060, 2'd2, 1'b0, 1'b0, 16'h0000, 1'b1, 16'h00A5, 20'h00060},
    '{16'hFFFF, 16'hFFFF, 2'd3, 1'b0, 1'b1, 16'h8001, 1'b0, 16'h0000, 20'h0FFEF}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chkIdle(input string tag);
    chk(reqReady == 1'b1, {tag, " R1 ready"}, reqReady, 1);
    chk({ale, rdN, wrN, denN, adOe, doneValid} == 6'b011100, {tag, " R1 strobes"},
        {ale, rdN, wrN, denN, adOe, doneValid}, 6'b011100);
    chk(busHi == 4'h0, {tag, " R1 busHi"}, busHi, 0);
    chk(memIo == 1'b1 && dtR == 1'b0, {tag, " R5 R6 idle level"}, {memIo, dtR}, 2'b10);
  endtask

  task automatic runVec(input vec_t v, input int idx);
    @(negedge clk);
    chk(reqReady == 1'b1, $sformatf("v%0d R2 ready before", idx), reqReady, 1);
    reqValid = 1'b1; reqSeg = v.seg; reqOff = v.off; reqSegId = v.sid;
    reqIsMem = v.mem; reqIsWrite = v.wr; reqWData = v.wd; reqIntEn = v.ie;
    @(negedge clk); // T1
    chk(ale == 1'b1, $sformatf("v%0d R4 ale T1", idx), ale, 1);
    chk(adOe && adOut == v.pa[15:0], $sformatf("v%0d R3 low addr", idx), {adOe, adOut}, {1'b1, v.pa[15:0]});
    chk(busHi == v.pa[19:16], $sformatf("v%0d R3 high addr", idx), busHi, v.pa[19:16]);
    chk(denN && rdN && wrN, $sformatf("v%0d R7 R8 T1 inactive", idx), {denN, rdN, wrN}, 3'b111);
    chk(memIo == v.mem, $sformatf("v%0d R5 memIo T1", idx), memIo, v.mem);
    chk(dtR == v.wr, $sformatf("v%0d R6 dtR T1", idx), dtR, v.wr);
    chk(!doneValid && !reqReady, $sformatf("v%0d R2 busy T1", idx), {doneValid, reqReady}, 0);
    // disturb request inputs while busy: must be ignored (R2)
    reqSeg = ~v.seg; reqOff = ~v.off; reqSegId = ~v.sid; reqIsMem = ~v.mem;
    reqIsWrite = ~v.wr; reqWData = ~v.wd; reqIntEn = ~v.ie;
    for (int ph = 2; ph <= 4; ph++) begin
      @(negedge clk);
      chk(!ale, $sformatf("v%0d T%0d R4 ale low", idx, ph), ale, 0);
      chk(!denN, $sformatf("v%0d T%0d R8 denN", idx, ph), denN, 0);
      chk(busHi == {1'b0, v.ie, v.sid}, $sformatf("v%0d T%0d R9 status", idx, ph), busHi, {1'b0, v.ie, v.sid});
      chk(rdN == v.wr && wrN == !v.wr, $sformatf("v%0d T%0d R7 strobes", idx, ph), {rdN, wrN}, {v.wr, !v.wr});
      chk(memIo == v.mem && dtR == v.wr, $sformatf("v%0d T%0d R5 R6 held", idx, ph), {memIo, dtR}, {v.mem, v.wr});
      chk(adOe == v.wr, $sformatf("v%0d T%0d R10 adOe", idx, ph), adOe, v.wr);
      if (v.wr) chk(adOut == v.wd, $sformatf("v%0d T%0d R10 wdata", idx, ph), adOut, v.wd);
      chk(doneValid == (ph == 4), $sformatf("v%0d T%0d R2 done", idx, ph), doneValid, (ph == 4));
      chk(!reqReady, $sformatf("v%0d T%0d R2 not ready", idx, ph), reqReady, 0);
      if (ph == 3) adIn = v.rd;
      if (ph == 4) begin
        if (!v.wr) chk(rdData == v.rd, $sformatf("v%0d R11 rdData T4", idx), rdData, v.rd);
        adIn = ~v.rd;
        reqValid = 1'b0;
      end
    end
    @(negedge clk); // idle
    chkIdle($sformatf("v%0d after R2", idx));
    if (!v.wr) chk(rdData == v.rd, $sformatf("v%0d R11 rdData held", idx), rdData, v.rd);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chkIdle("in reset R1");
    rstN = 1'b1;
    @(negedge clk);
    chkIdle("after reset R1");

    foreach (VECS[i]) runVec(VECS[i], i);

    // R2: request held high while idle is taken at once, input low is not
    @(negedge clk);
    chk(reqReady && !ale, "R2 no request no cycle", {reqReady, ale}, 2'b10);

    // R1: reset in the middle of a cycle
    reqValid = 1'b1; reqSeg = 16'h1000; reqOff = 16'h0001; reqIsWrite = 1'b1; reqIsMem = 1'b1;
    @(negedge clk);
    chk(ale == 1'b1, "R4 ale before mid reset", ale, 1);
    reqValid = 1'b0;
    @(negedge clk);
    chk(!wrN, "R7 write strobe before mid reset", wrN, 0);
    rstN = 1'b0;
    @(negedge clk);
    chkIdle("mid reset R1");
    rstN = 1'b1;
    @(negedge clk);
    chkIdle("after mid reset R1");

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule